// File: doc/BRIEF.md
# Cycle Compare Bank

A bank of 64-bit comparators that watch an external time counter. Each comparator holds a programmed value. When it is enabled and the counter equals that value, it sends a one-cycle match pulse to neighbouring blocks and sets a sticky status bit. Software clears a status bit by writing 1 to it. The counter itself lives outside this block.

Comparator 0 has a second role. When the cycle-reset option is on, its match tells the counter to load zero, so the counter becomes a cycle timer. To get a cycle of T ns, program comparator 0 with T minus the counter's per-tick increment: the counter then wraps every T ns. Without shadow mode, a write to a compare value takes effect at once. With shadow mode on, writes to compare values wait in a holding copy and move into the active comparators at the moment comparator 0 wraps the counter. This lets software retarget a whole cycle without tearing a 64-bit value across a wrap.

Access goes through a simple word-wide write port and a read port with one cycle of latency. The control word sits at address 0 and the status word at address 1. Comparator n's low word sits at address 2+2n and its high word at address 3+2n.

Top module: `cyc_cmp_bank`

## Requirements
- R1: After reset the control word, the status word and every compare value read as zero, `match_o` is all zero and `cnt_clr_o` is low.
- R2: A write to address 2+2n sets bits 31:0 of comparator n's value, and a write to address 3+2n sets bits 63:32. A read of either address returns that half of the active value on `rd_data` one cycle after `rd_addr` is presented.
- R3: Comparator n is enabled by control bit n+1. When an enabled comparator's active value equals `cnt_i`, `match_o[n]` is high in the following cycle. A disabled comparator never raises its match. A partial match (low word only) does not count.
- R4: Status bit n (address 1) is set by a match on comparator n and stays set until a write to address 1 with bit n at 1. Writing 0 leaves the bit unchanged. A match and a clear in the same cycle leave the bit set.
- R5: `cnt_clr_o` is high in the same cycle that `cnt_i` equals comparator 0's active value, provided control bit 0 (cycle reset) and control bit 1 (comparator 0 enable) are both set. With control bit 0 clear it stays low.
- R6: A wrap caused by comparator 0 still raises `match_o[0]` in the next cycle and sets status bit 0.
- R7: With control bit 17 (shadow mode) set, writes to compare values leave the active value, its read-back and its matching unchanged. The most recently written value becomes active in the cycle after `cnt_clr_o` is high.
- R8: With shadow mode clear, a written compare value is active, and readable, from the next cycle.
- R9: The control word keeps only bit 0, bits N:1 and bit 17. Every other bit reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Current time counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| match_o | output | N | One-cycle match pulse per comparator |
| cnt_clr_o | output | 1 | Request for the counter to load zero (cycle wrap) |

## Verification
The bench drives the counter value directly, so each match condition is placed exactly.

It checks that a value matching only in its low word gives no match, and that a disabled comparator stays silent; a design comparing 32 bits, or ignoring the enable, would pulse. It checks that a status clear written in the same cycle as a new match loses to the match; a design giving the clear priority would drop an event.

Shadow mode gets the closest look. A new value must stay invisible, both in read-back and in matching, until the wrap, and must take over right after it. A design that loaded at once, or never loaded, would match on the wrong count.

It also checks that the wrap request appears in the very cycle of the comparator 0 match. A registered request would stretch every cycle by one tick.

// File: rtl/cyc_cmp_pkg.sv
package cyc_cmp_pkg;
  localparam int CFG_W      = 18;
  localparam int SHADOW_BIT = 17;
  localparam int WRAP_BIT   = 0;
  localparam int MAX_CMP    = 16;
  localparam int ADDR_CFG   = 0;
  localparam int ADDR_STS   = 1;
  localparam int VAL_BASE   = 2;
  localparam int VAL_W      = 64;
  localparam int WORD_W     = 32;
endpackage

// File: rtl/cyc_cmp_slot.sv
module cyc_cmp_slot
  import cyc_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [VAL_W-1:0]  cnt_i,
  input  logic              en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              shadow_on,
  input  logic              load_shd,
  output logic [VAL_W-1:0]  act_q,
  output logic              hit
);
  logic [VAL_W-1:0] shd_q;

  // holding copy always tracks the written value
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
    end else begin
      if (wr_lo) shd_q[WORD_W-1:0]     <= wr_data;
      if (wr_hi) shd_q[VAL_W-1:WORD_W] <= wr_data;
    end
  end

  // active value: direct writes, or transfer at the wrap in shadow mode
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (!shadow_on) begin
      if (wr_lo) act_q[WORD_W-1:0]     <= wr_data;
      if (wr_hi) act_q[VAL_W-1:WORD_W] <= wr_data;
    end else if (load_shd) begin
      act_q <= shd_q;
    end
  end

  assign hit = en && (act_q == cnt_i);
endmodule

// File: rtl/cyc_cmp_sticky.sv
module cyc_cmp_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_q
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/cyc_cmp_bank.sv
module cyc_cmp_bank
  import cyc_cmp_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = $clog2(2 * N + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       cnt_i,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  output logic [N-1:0]      match_o,
  output logic              cnt_clr_o
);
  localparam int CFG_MASK_I = (1 << SHADOW_BIT) | ((1 << (N + 1)) - 1);
  localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'(CFG_MASK_I);

  logic [CFG_W-1:0] cfg_q;
  logic [N-1:0]     sts_q;
  logic [N-1:0]     hit_vec;
  logic [N-1:0]     sts_clr;
  logic [VAL_W-1:0] act_arr [N];
  logic [31:0]      rd_next;
  logic             shadow_on;
  logic             wrap;

  assign shadow_on = cfg_q[SHADOW_BIT];
  assign wrap      = cfg_q[WRAP_BIT] && hit_vec[0];
  assign cnt_clr_o = wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en && wr_addr == AW'(ADDR_CFG)) begin
      cfg_q <= wr_data[CFG_W-1:0] & CFG_MASK;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    cyc_cmp_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .cnt_i    (cnt_i),
      .en       (cfg_q[g+1]),
      .wr_lo    (wr_en && wr_addr == AW'(VAL_BASE + 2 * g)),
      .wr_hi    (wr_en && wr_addr == AW'(VAL_BASE + 2 * g + 1)),
      .wr_data  (wr_data),
      .shadow_on(shadow_on),
      .load_shd (wrap),
      .act_q    (act_arr[g]),
      .hit      (hit_vec[g])
    );
  end

  assign sts_clr = (wr_en && wr_addr == AW'(ADDR_STS)) ? wr_data[N-1:0] : '0;

  cyc_cmp_sticky #(.N(N)) u_sticky (
    .clk  (clk),
    .rst  (rst),
    .set_i(hit_vec),
    .clr_i(sts_clr),
    .sts_q(sts_q)
  );

  always_ff @(posedge clk) begin
    if (rst) match_o <= '0;
    else     match_o <= hit_vec;
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == AW'(ADDR_CFG)) rd_next = 32'(cfg_q);
    if (rd_addr == AW'(ADDR_STS)) rd_next = 32'(sts_q);
    for (int n = 0; n < N; n++) begin
      if (rd_addr == AW'(VAL_BASE + 2 * n))     rd_next = act_arr[n][31:0];
      if (rd_addr == AW'(VAL_BASE + 2 * n + 1)) rd_next = act_arr[n][63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/cyc_cmp_chk.sv
module cyc_cmp_chk #(
  parameter int N  = 4,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_clr_o,
  input logic [N-1:0]  match_o,
  input logic [17:0]   cfg_q,
  input logic [N-1:0]  sts_q,
  input logic [63:0]   act0,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // R3
    match_en_chk: assert property (@(posedge clk) disable iff (rst)
      match_o[i] |-> $past(cfg_q[i+1]));
    // R4
    match_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      match_o[i] |-> sts_q[i]);
    // R4
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(sts_q[i]) |-> $past(wr_en && wr_addr == AW'(1) && wr_data[i]));
  end

  // R5
  wrap_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr_o |-> (cfg_q[0] && cfg_q[1]));
  // R6
  wrap_flags_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr_o |=> (sts_q[0] && match_o[0]));
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[17] && !cnt_clr_o) |=> $stable(act0));
endmodule

bind cyc_cmp_bank cyc_cmp_chk #(.N(N), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_clr_o(cnt_clr_o),
  .match_o  (match_o),
  .cfg_q    (cfg_q),
  .sts_q    (sts_q),
  .act0     (act_arr[0]),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/test_cyc_cmp_bank.sv
module test_cyc_cmp_bank;
  localparam int N  = 4;
  localparam int AW = $clog2(2 * N + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   cnt_i = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  match_o;
  logic          cnt_clr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cyc_cmp_bank #(.N(N)) i_cyc_cmp_bank (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .match_o(match_o), .cnt_clr_o(cnt_clr_o)
  );

  typedef struct packed {
    logic [63:0] c;
    logic [3:0]  m;
    logic        clr;
  } vec_t;

  // cmp0=100, cmp1=200, cmp2=300 (disabled), cmp3=1_00000005
  localparam vec_t VECS [6] = '{
    '{c: 64'd100,          m: 4'b0001, clr: 1'b0},
    '{c: 64'd200,          m: 4'b0010, clr: 1'b0},
    '{c: 64'd300,          m: 4'b0000, clr: 1'b0},
    '{c: 64'd5,            m: 4'b0000, clr: 1'b0},
    '{c: 64'h1_0000_0005,  m: 4'b1000, clr: 1'b0},
    '{c: 64'd101,          m: 4'b0000, clr: 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(posedge clk); #1;
    d = rd_data;
  endtask

  // one cycle of counter value c, then back to 0
  task automatic step(input logic [63:0] c, input logic [3:0] m_exp,
                      input logic clr_exp, input string req);
    @(negedge clk);
    cnt_i = c;
    #1 chk({req, " wrap request"}, 64'(cnt_clr_o), 64'(clr_exp));
    @(posedge clk); #1;
    chk({req, " match pulse"}, 64'(match_o), 64'(m_exp));
    @(negedge clk);
    cnt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 match_o", 64'(match_o), 0);
    chk("R1 cnt_clr_o", 64'(cnt_clr_o), 0);
    rd(0, d); chk("R1 control", 64'(d), 0);
    rd(1, d); chk("R1 status", 64'(d), 0);
    rd(4, d); chk("R1 value", 64'(d), 0);

    // program values, R2 and R8 read-back
    wr(2, 32'd100);
    wr(4, 32'd200);
    wr(6, 32'd300);
    wr(8, 32'd5); wr(9, 32'd1);
    rd(4, d); chk("R2 low word", 64'(d), 200);
    rd(9, d); chk("R2 high word", 64'(d), 1);

    // R9 control mask
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R9 control mask", 64'(d), 64'h2001F);
    wr(0, 32'h16); // enable cmp0, cmp1, cmp3; no wrap, no shadow

    // R3 vector walk
    foreach (VECS[i]) begin
      @(negedge clk);
      cnt_i = VECS[i].c;
      #1 chk("R5 no wrap when disabled", 64'(cnt_clr_o), 64'(VECS[i].clr));
      @(posedge clk); #1;
      chk("R3 match vector", 64'(match_o), 64'(VECS[i].m));
    end
    @(negedge clk) cnt_i = '0;

    // R4 sticky status
    rd(1, d); chk("R4 sticky set", 64'(d), 64'b1011);
    wr(1, 32'h0);
    rd(1, d); chk("R4 write zero ignored", 64'(d), 64'b1011);
    wr(1, 32'h2);
    rd(1, d); chk("R4 clear one bit", 64'(d), 64'b1001);
    wr(1, 32'h1);
    rd(1, d); chk("R4 clear bit0", 64'(d), 64'b1000);
    cnt_i = 64'd100;          // set and clear in the same cycle
    wr(1, 32'h1);
    cnt_i = '0;
    rd(1, d); chk("R4 set wins over clear", 64'(d), 64'b1001);

    // R5 / R6 wrap
    wr(1, 32'hF);
    wr(0, 32'h17);
    step(64'd100, 4'b0001, 1'b1, "R5 R6");
    rd(1, d); chk("R6 status bit0 on wrap", 64'(d), 64'b0001);

    // R8 direct update
    wr(4, 32'd250);
    rd(4, d); chk("R8 direct update", 64'(d), 250);

    // R7 shadow mode
    wr(0, 32'h2_0017);
    wr(4, 32'd260);
    rd(4, d); chk("R7 held before wrap", 64'(d), 250);
    step(64'd250, 4'b0010, 1'b0, "R7 old value active");
    step(64'd260, 4'b0000, 1'b0, "R7 new value not yet active");
    step(64'd100, 4'b0001, 1'b1, "R7 wrap");
    rd(4, d); chk("R7 loaded at wrap", 64'(d), 260);
    step(64'd260, 4'b0010, 1'b0, "R7 new value active");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule